// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. A request carries the virtual address, whether the access is a write, and whether it comes from user mode. The walker reads the directory entry, and either stops there when that entry maps a 4 MB region on its own, or goes on to read a second-level entry that maps a 4 KB frame. Both levels are 4 KB blocks of 1024 four-byte entries. The base of the directory comes from a root register input.

Rights are checked in a fixed order: presence at each level first, then the user/supervisor right, then the write right. The user and write rights that apply are the more restrictive of the two levels. A successful walk sets the sticky accessed flag in every entry it used, and the dirty flag in the final entry on a write. Each flag is written back through the same word-wide memory port, and only when it was clear. The block ends every request with exactly one result pulse, which carries the physical address and the cache attribute bits on success or a cause code on a fault.

Top module: `pt_walker`

## Requirements
- R1: For a 4 KB mapping, the directory entry is read from address {root[31:12], va[31:22], 2'b00}, the table entry from {directory entry[31:12], va[21:12], 2'b00}, and the result address is {table entry[31:12], va[11:0]}.
- R2: A present directory entry with bit 7 set maps a 4 MB page: the result address is {directory entry[31:22], va[21:0]}, `big_page` is 1, and only one memory read takes place.
- R3: Bit 0 is the present flag, tested first at each level. If it is clear, the walk ends with a fault of cause 1, and a clear bit 0 in the directory entry means no table read.
- R4: Bit 2 is the user right (0 = supervisor only). A user access where this bit is clear in either entry used faults with cause 2; this test comes before the write test.
- R5: Bit 1 is the write right (0 = read only). A write, in either mode, where this bit is clear in either entry used faults with cause 3.
- R6: On success `attr_wt`, `attr_cd` and `attr_global` carry bits 3, 4 and 8 of the final entry (the table entry, or the directory entry for a 4 MB page).
- R7: On success the accessed flag (bit 5) is set in every entry read, and each entry is written back only if its value changes; no change means no write.
- R8: The dirty flag (bit 6) is set only in the final entry, and only on a successful write; a read never sets it.
- R9: A walk that ends in a fault issues no memory write and leaves every entry unchanged.
- R10: A request is taken only while `req_ready` is high (idle); each request produces exactly one pulse on `walk_done` or `walk_fault`, one cycle wide, after all its write-backs. `fault_cause` is 0 with `walk_done`.
- R11: A memory access completes in a cycle where `mem_valid` and `mem_ready` are both high; until then the walker holds `mem_addr`, `mem_we` and `mem_wdata` steady, and read data is taken from `mem_rdata` in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Physical base of the directory (bits 31:12 used) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| mem_valid | output | 1 | Memory access requested |
| mem_we | output | 1 | 1 = write-back of an entry, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for a write-back |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Entry read, valid with `mem_ready` |
| walk_done | output | 1 | One-cycle success pulse |
| walk_fault | output | 1 | One-cycle fault pulse |
| fault_cause | output | 2 | 0 none, 1 not present, 2 privilege, 3 read only |
| pa | output | 32 | Translated physical address |
| attr_wt | output | 1 | Write-through attribute |
| attr_cd | output | 1 | Cache-disable attribute |
| attr_global | output | 1 | Global attribute |
| big_page | output | 1 | Result came from a 4 MB mapping |

## Verification
On every cycle the assertions check the memory handshake (requests held steady while stalled), that a write-back always carries the accessed flag, that every fault follows a read rather than a write, that a result pulse never shows success and fault together and matches its cause code, and that a taken request drops `req_ready`. Whether the translated address, the attribute bits, the fault priority and the exact flag updates in memory are right can only be shown by the bench, which sweeps every combination of present, write and user bits at both levels against both access types and both modes, with preset accessed and dirty flags and memory stalls mixed in, and compares memory contents and access counts with values it computes itself.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
   // Entry bit positions; these are decoded by software and by the walker.
   localparam int unsigned PTE_P   = 0;
   localparam int unsigned PTE_RW  = 1;
   localparam int unsigned PTE_US  = 2;
   localparam int unsigned PTE_WT  = 3;
   localparam int unsigned PTE_CD  = 4;
   localparam int unsigned PTE_ACC = 5;
   localparam int unsigned PTE_DRT = 6;
   localparam int unsigned PTE_PS  = 7;
   localparam int unsigned PTE_GLB = 8;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_RD_DIR = 3'd1,
      ST_RD_TBL = 3'd2,
      ST_WR_DIR = 3'd3,
      ST_WR_TBL = 3'd4
   } walk_st_e;

   localparam logic [1:0] CAUSE_NONE   = 2'd0;
   localparam logic [1:0] CAUSE_ABSENT = 2'd1;
   localparam logic [1:0] CAUSE_PRIV   = 2'd2;
   localparam logic [1:0] CAUSE_RDONLY = 2'd3;
endpackage

// File: rtl/pt_perm_check.sv
module pt_perm_check
   import pt_walk_pkg::*;
(
   input  logic       dir_rw,
   input  logic       dir_us,
   input  logic       leaf_rw,
   input  logic       leaf_us,
   input  logic       is_write,
   input  logic       is_user,
   output logic       grant,
   output logic [1:0] why
);
   logic eff_us, eff_rw;

   // Effective right is the stricter of both levels; user test precedes write test.
   always_comb begin
      eff_us = dir_us & leaf_us;
      eff_rw = dir_rw & leaf_rw;
      why    = CAUSE_NONE;
      if (is_user && !eff_us)
         why = CAUSE_PRIV;
      else if (is_write && !eff_rw)
         why = CAUSE_RDONLY;
      grant = (why == CAUSE_NONE);
   end
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
   parameter int unsigned IDX_W = 10,
   parameter int unsigned OFF_W = 12,
   parameter int unsigned ENT_W = 32
) (
   input  logic [ENT_W-OFF_W-1:0]     root_frame,
   input  logic [2*IDX_W+OFF_W-1:0]   va,
   input  logic [ENT_W-OFF_W-1:0]     dir_frame,
   input  logic [ENT_W-OFF_W-1:0]     leaf_frame,
   output logic [ENT_W-1:0]           dir_addr,
   output logic [ENT_W-1:0]           tbl_addr,
   output logic [ENT_W-1:0]           pa_small,
   output logic [ENT_W-1:0]           pa_large
);
   localparam int unsigned VA_W = 2*IDX_W + OFF_W;
   localparam int unsigned SH   = $clog2(ENT_W/8);
   localparam int unsigned LOFF = IDX_W + OFF_W;
   localparam int unsigned FR_W = ENT_W - OFF_W;

   generate
      if (ENT_W % 8 != 0) begin : g_bad_bytes
         $error("entry width must be whole bytes");
      end
      if (IDX_W + SH != OFF_W) begin : g_bad_block
         $error("one table must fill exactly one page");
      end
      if (OFF_W < 9) begin : g_bad_flags
         $error("page offset too narrow for the flag bits");
      end
      if (FR_W <= IDX_W) begin : g_bad_large
         $error("entry too narrow for a large-page frame");
      end
   endgenerate

   assign dir_addr = {root_frame, va[VA_W-1:LOFF], {SH{1'b0}}};
   assign tbl_addr = {dir_frame, va[LOFF-1:OFF_W], {SH{1'b0}}};
   assign pa_small = {leaf_frame, va[OFF_W-1:0]};
   assign pa_large = {dir_frame[FR_W-1:IDX_W], va[LOFF-1:0]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walk_pkg::*;
#(
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned OFF_W    = 12,
   parameter int unsigned ENT_W    = 32,
   parameter bit          LARGE_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ENT_W-1:0]         root_base,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [2*IDX_W+OFF_W-1:0] req_va,
   input  logic                     req_write,
   input  logic                     req_user,
   output logic                     mem_valid,
   output logic                     mem_we,
   output logic [ENT_W-1:0]         mem_addr,
   output logic [ENT_W-1:0]         mem_wdata,
   input  logic                     mem_ready,
   input  logic [ENT_W-1:0]         mem_rdata,
   output logic                     walk_done,
   output logic                     walk_fault,
   output logic [1:0]               fault_cause,
   output logic [ENT_W-1:0]         pa,
   output logic                     attr_wt,
   output logic                     attr_cd,
   output logic                     attr_global,
   output logic                     big_page
);
   localparam int unsigned VA_W = 2*IDX_W + OFF_W;
   localparam int unsigned FR_W = ENT_W - OFF_W;
   localparam logic [ENT_W-1:0] M_ACC = ENT_W'(1) << PTE_ACC;
   localparam logic [ENT_W-1:0] M_DRT = ENT_W'(1) << PTE_DRT;

   walk_st_e          st_q, st_d;
   logic [VA_W-1:0]   va_q;
   logic              wr_q, usr_q, big_q, big_d, tw_q, tw_d;
   logic [FR_W-1:0]   root_q;
   logic [ENT_W-1:0]  pde_q, pde_d, pte_q, pte_d;
   logic              done_q, fault_q, wt_q, cd_q, glb_q, bigo_q;
   logic [1:0]        cause_q, bad_why, why;
   logic [ENT_W-1:0]  pa_q;
   logic              hs, ps_hit, big_now, grant, end_ok, end_bad;
   logic [ENT_W-1:0]  dir_now, leaf_now, attr_ent, new_dir, new_leaf;
   logic [ENT_W-1:0]  dir_addr, tbl_addr, pa_small, pa_large;
   logic              root_unused;

   assign root_unused = ^root_base[OFF_W-1:0];

   // Variant: honour the large-page bit, or treat every directory entry as a pointer.
   generate
      if (LARGE_EN) begin : g_large
         assign ps_hit = mem_rdata[PTE_PS];
      end else begin : g_small_only
         assign ps_hit = 1'b0;
      end
   endgenerate

   assign hs       = mem_valid & mem_ready;
   assign dir_now  = (st_q == ST_RD_DIR) ? mem_rdata : pde_q;
   assign leaf_now = (st_q == ST_RD_TBL) ? mem_rdata : pte_q;
   assign big_now  = (st_q == ST_RD_DIR) ? ps_hit : big_q;
   assign attr_ent = big_now ? dir_now : leaf_now;
   assign new_dir  = dir_now  | M_ACC | ((big_now && wr_q) ? M_DRT : '0);
   assign new_leaf = leaf_now | M_ACC | (wr_q ? M_DRT : '0);

   pt_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_W(ENT_W)) addr_i (
      .root_frame (root_q),
      .va         (va_q),
      .dir_frame  (dir_now[ENT_W-1:OFF_W]),
      .leaf_frame (leaf_now[ENT_W-1:OFF_W]),
      .dir_addr   (dir_addr),
      .tbl_addr   (tbl_addr),
      .pa_small   (pa_small),
      .pa_large   (pa_large)
   );

   pt_perm_check perm_i (
      .dir_rw   (dir_now[PTE_RW]),
      .dir_us   (dir_now[PTE_US]),
      .leaf_rw  (big_now ? 1'b1 : leaf_now[PTE_RW]),
      .leaf_us  (big_now ? 1'b1 : leaf_now[PTE_US]),
      .is_write (wr_q),
      .is_user  (usr_q),
      .grant    (grant),
      .why      (why)
   );

   always_comb begin
      st_d    = st_q;
      pde_d   = pde_q;
      pte_d   = pte_q;
      big_d   = big_q;
      tw_d    = tw_q;
      end_ok  = 1'b0;
      end_bad = 1'b0;
      bad_why = CAUSE_NONE;
      case (st_q)
         ST_IDLE: if (req_valid) st_d = ST_RD_DIR;
         ST_RD_DIR: if (hs) begin
            if (!mem_rdata[PTE_P]) begin
               end_bad = 1'b1;
               bad_why = CAUSE_ABSENT;
            end else if (ps_hit) begin
               big_d = 1'b1;
               if (!grant) begin
                  end_bad = 1'b1;
                  bad_why = why;
               end else begin
                  pde_d = new_dir;
                  if (new_dir != mem_rdata) st_d = ST_WR_DIR;
                  else end_ok = 1'b1;
               end
            end else begin
               big_d = 1'b0;
               pde_d = mem_rdata;
               st_d  = ST_RD_TBL;
            end
         end
         ST_RD_TBL: if (hs) begin
            if (!mem_rdata[PTE_P]) begin
               end_bad = 1'b1;
               bad_why = CAUSE_ABSENT;
            end else if (!grant) begin
               end_bad = 1'b1;
               bad_why = why;
            end else begin
               pde_d = new_dir;
               pte_d = new_leaf;
               tw_d  = (new_leaf != mem_rdata);
               if (new_dir != pde_q)         st_d = ST_WR_DIR;
               else if (new_leaf != mem_rdata) st_d = ST_WR_TBL;
               else                            end_ok = 1'b1;
            end
         end
         ST_WR_DIR: if (hs) begin
            if (!big_q && tw_q) st_d = ST_WR_TBL;
            else                end_ok = 1'b1;
         end
         ST_WR_TBL: if (hs) end_ok = 1'b1;
         default: st_d = ST_IDLE;
      endcase
      if (end_ok || end_bad) st_d = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         va_q    <= '0;
         wr_q    <= 1'b0;
         usr_q   <= 1'b0;
         root_q  <= '0;
         pde_q   <= '0;
         pte_q   <= '0;
         big_q   <= 1'b0;
         tw_q    <= 1'b0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         cause_q <= CAUSE_NONE;
         pa_q    <= '0;
         wt_q    <= 1'b0;
         cd_q    <= 1'b0;
         glb_q   <= 1'b0;
         bigo_q  <= 1'b0;
      end else begin
         st_q    <= st_d;
         pde_q   <= pde_d;
         pte_q   <= pte_d;
         big_q   <= big_d;
         tw_q    <= tw_d;
         done_q  <= end_ok;
         fault_q <= end_bad;
         if (st_q == ST_IDLE && req_valid) begin
            va_q   <= req_va;
            wr_q   <= req_write;
            usr_q  <= req_user;
            root_q <= root_base[ENT_W-1:OFF_W];
         end
         if (end_ok || end_bad) cause_q <= bad_why;
         if (end_ok) begin
            pa_q   <= big_now ? pa_large : pa_small;
            wt_q   <= attr_ent[PTE_WT];
            cd_q   <= attr_ent[PTE_CD];
            glb_q  <= attr_ent[PTE_GLB];
            bigo_q <= big_now;
         end
      end
   end

   assign req_ready   = (st_q == ST_IDLE);
   assign mem_valid   = (st_q != ST_IDLE);
   assign mem_we      = (st_q == ST_WR_DIR) || (st_q == ST_WR_TBL);
   assign mem_addr    = (st_q == ST_RD_DIR || st_q == ST_WR_DIR) ? dir_addr : tbl_addr;
   assign mem_wdata   = (st_q == ST_WR_DIR) ? pde_q : pte_q;
   assign walk_done   = done_q;
   assign walk_fault  = fault_q;
   assign fault_cause = cause_q;
   assign pa          = pa_q;
   assign attr_wt     = wt_q;
   assign attr_cd     = cd_q;
   assign attr_global = glb_q;
   assign big_page    = bigo_q;

   // R11: a stalled access keeps its address, direction and data.
   a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   // R7: every write-back carries the accessed flag.
   a_r7_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_we |-> mem_wdata[PTE_ACC]);

   // R9: a fault always follows a completed read, never a write-back.
   a_r9_fault_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      walk_fault |-> $past(mem_valid && mem_ready && !mem_we));

   // R10: success and fault are never reported together.
   a_r10_single_result: assert property (@(posedge clk) disable iff (!rst_n)
      !(walk_done && walk_fault));

   // R10: a taken request makes the walker busy.
   a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   // R3: a fault pulse always names a cause; a success pulse never does.
   a_r3_cause_matches: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_fault |-> fault_cause != CAUSE_NONE) and (walk_done |-> fault_cause == CAUSE_NONE));
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] root_base = 32'h0000_2000;
   logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_ready, mem_valid, mem_we, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, pa;
   logic        walk_done, walk_fault, attr_wt, attr_cd, attr_global, big_page;
   logic [1:0]  fault_cause;

   logic [31:0] mem [0:4095];
   logic        rdy_q = 1'b0, stall = 1'b0;
   logic        pk_en = 1'b0;
   logic [11:0] pk_idx = '0;
   logic [31:0] pk_dat = '0;
   int          wr_cnt = 0, rd_cnt = 0, pl_cnt = 0;
   int          n_chk = 0, n_fail = 0;

   logic        g_done, g_fault, g_wt, g_cd, g_glb, g_big;
   logic [1:0]  g_cause;
   logic [31:0] g_pa;
   int          d_wr, d_rd, d_pl;

   always #5 clk = ~clk;

   pt_walker dut_i (
      .clk(clk), .rst_n(rst_n), .root_base(root_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .req_write(req_write), .req_user(req_user),
      .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .walk_done(walk_done), .walk_fault(walk_fault), .fault_cause(fault_cause),
      .pa(pa), .attr_wt(attr_wt), .attr_cd(attr_cd), .attr_global(attr_global),
      .big_page(big_page)
   );

   assign mem_ready = stall ? rdy_q : 1'b1;
   assign mem_rdata = mem[mem_addr[13:2]];

   // Memory model: word array, bench pokes, DUT accesses and counters.
   always @(posedge clk) begin
      rdy_q <= ~rdy_q;
      if (!rst_n) begin
         for (int i = 0; i < 4096; i++) mem[i] <= '0;
      end else if (pk_en) begin
         mem[pk_idx] <= pk_dat;
      end else if (mem_valid && mem_ready) begin
         if (mem_we) begin
            mem[mem_addr[13:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            rd_cnt <= rd_cnt + 1;
         end
      end
      if (walk_done || walk_fault) pl_cnt <= pl_cnt + 1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic poke(input int idx, input logic [31:0] d);
      @(negedge clk);
      pk_en = 1'b1; pk_idx = idx[11:0]; pk_dat = d;
      @(negedge clk);
      pk_en = 1'b0;
   endtask

   task automatic walk(input logic [31:0] va, input logic wr, input logic usr);
      int b_wr, b_rd, b_pl;
      bit seen;
      @(negedge clk);
      b_wr = wr_cnt; b_rd = rd_cnt; b_pl = pl_cnt;
      chk("R10 ready when idle", {31'd0, req_ready}, 32'd1);
      req_va = va; req_write = wr; req_user = usr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      seen = 1'b0;
      for (int k = 0; k < 100; k++) begin
         if (walk_done || walk_fault) begin
            seen = 1'b1;
            break;
         end
         @(negedge clk);
      end
      chk("R10 result seen", {31'd0, seen}, 32'd1);
      g_done = walk_done; g_fault = walk_fault; g_cause = fault_cause; g_pa = pa;
      g_wt = attr_wt; g_cd = attr_cd; g_glb = attr_global; g_big = big_page;
      repeat (3) @(negedge clk);
      d_wr = wr_cnt - b_wr; d_rd = rd_cnt - b_rd; d_pl = pl_cnt - b_pl;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset done", {31'd0, walk_done}, 32'd0);
      chk("R10 reset fault", {31'd0, walk_fault}, 32'd0);
      chk("R11 reset mem_valid", {31'd0, mem_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset ready", {31'd0, req_ready}, 32'd1);

      // 4 KB mappings: every combination of present/write/user at both levels,
      // both access types and both modes.
      for (int c = 0; c < 256; c++) begin
         logic p1, rw1, us1, p2, rw2, us2, wr, usr, a1, a2, d2, wt, cd, gl;
         int di, ti, xw, xr;
         logic [31:0] va, pde, pte, fr, exp_pde, exp_pte;
         logic [1:0] cause;
         {usr, wr, us2, rw2, p2, us1, rw1, p1} = c[7:0];
         a1 = c[1] ^ c[3]; a2 = c[4] ^ c[0]; d2 = c[2] & c[5];
         wt = c[0] ^ c[6]; cd = c[1] ^ c[7]; gl = c[3] ^ c[5];
         stall = c[2] ^ c[4];
         di = (c * 37 + 3) % 1024;
         ti = (c * 11 + 5) % 1024;
         va = {di[9:0], ti[9:0], 12'((c * 291) % 4096)};
         fr = 32'((c * 40503 + 12345) % 1048576);
         pde = 32'h0000_1000 | {26'd0, a1, 2'b00, us1, rw1, p1};
         pte = {fr[19:0], 12'd0} | {23'd0, gl, 1'b0, d2, a2, cd, wt, us2, rw2, p2};
         poke(2048 + di, pde);
         poke(1024 + ti, pte);
         walk(va, wr, usr);
         if (!p1 || !p2)                 cause = 2'd1;
         else if (usr && !(us1 && us2))  cause = 2'd2;
         else if (wr && !(rw1 && rw2))   cause = 2'd3;
         else                            cause = 2'd0;
         chk("R10 one pulse", d_pl, 1);
         chk("R3 R4 R5 fault flag", {31'd0, g_fault}, {31'd0, cause != 2'd0});
         chk("R3 R4 R5 cause", {30'd0, g_cause}, {30'd0, cause});
         chk("R3 reads", d_rd, p1 ? 2 : 1);
         if (cause == 2'd0) begin
            exp_pde = pde | 32'h20;
            exp_pte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
            xw = (a1 ? 0 : 1) + ((!a2 || (wr && !d2)) ? 1 : 0);
            chk("R1 pa", g_pa, {fr[19:0], va[11:0]});
            chk("R6 attrs", {29'd0, g_wt, g_cd, g_glb}, {29'd0, wt, cd, gl});
            chk("R2 big flag clear", {31'd0, g_big}, 32'd0);
            chk("R7 dir entry", mem[2048 + di], exp_pde);
            chk("R7 R8 table entry", mem[1024 + ti], exp_pte);
            chk("R7 write count", d_wr, xw);
         end else begin
            chk("R9 no writes", d_wr, 0);
            chk("R9 dir unchanged", mem[2048 + di], pde);
            chk("R9 table unchanged", mem[1024 + ti], pte);
         end
         xr = 0;
      end

      // 4 MB mappings.
      for (int c = 0; c < 128; c++) begin
         logic p, rw, us, wr, usr, a, d, wt, cd, gl;
         int di, xw;
         logic [31:0] va, pde, exp_pde;
         logic [1:0] cause;
         {d, a, usr, wr, us, rw} = c[5:0];
         p = ~c[6] | c[0];
         wt = c[1] ^ c[4]; cd = c[2] ^ c[6]; gl = c[0] ^ c[3];
         stall = c[1] ^ c[5];
         di = (c * 53 + 7) % 1024;
         va = {di[9:0], 22'((c * 99991) % 4194304)};
         pde = {10'((c * 13 + 1) % 1024), 22'd0}
             | {23'd0, gl, 1'b1, d, a, cd, wt, us, rw, p};
         poke(2048 + di, pde);
         walk(va, wr, usr);
         if (!p)                 cause = 2'd1;
         else if (usr && !us)    cause = 2'd2;
         else if (wr && !rw)     cause = 2'd3;
         else                    cause = 2'd0;
         chk("R10 one pulse large", d_pl, 1);
         chk("R2 R3 R4 R5 cause large", {30'd0, g_cause}, {30'd0, cause});
         chk("R2 single read", d_rd, 1);
         if (cause == 2'd0) begin
            exp_pde = pde | 32'h20 | (wr ? 32'h40 : 32'h0);
            xw = (exp_pde != pde) ? 1 : 0;
            chk("R2 large pa", g_pa, {pde[31:22], va[21:0]});
            chk("R2 big flag", {31'd0, g_big}, 32'd1);
            chk("R6 large attrs", {29'd0, g_wt, g_cd, g_glb}, {29'd0, wt, cd, gl});
            chk("R8 large entry", mem[2048 + di], exp_pde);
            chk("R7 large write count", d_wr, xw);
         end else begin
            chk("R9 large no writes", d_wr, 0);
            chk("R9 large unchanged", mem[2048 + di], pde);
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R10 actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule